// File: doc/BRIEF.md
# Leaf Entry Accessed/Dirty Updater

After a page walk reaches its leaf entry, this block decides whether the accessed and dirty flags of that entry must change. If they must, it writes the change back with a single atomic compare-and-swap on a request/response memory port. Its inputs are the entry image the walker read, the entry's memory address and the kind of access behind the walk. There are three kinds: a plain read, a plain write, or a translation request that may ask for write. The translation request carries its own no-write flag.

When the compare-and-swap finds the entry has changed since the walker read it, the block returns the entry it found and asks the walker to fetch the entry again. Software or another translation agent may have changed it in that gap. Consecutive restarts are counted. Once the count reaches a set limit, the next mismatch ends the operation with an error. A memory error ends the operation with an access fault. The block reports write permission only together with a dirty bit that is set. A translation request that wants write on a read-only entry gets write denied, not a fault.

Top module: `pte_ad_updater`

## Requirements
- R1: `acc_kind` encoding: 0 is read, 1 is write, 2 is a translation request, and 3 is treated as read. Write intent is present for kind 1, and for kind 2 when `no_write` is 0. In the entry image, bit 2 is write permission, bit 6 is accessed and bit 7 is dirty.
- R2: Every successful completion returns an entry with the accessed bit set. All other bits of the read entry are kept.
- R3: The dirty bit is set, and `write_grant` is 1, only when write intent is present and the entry's write bit is 1. Otherwise the dirty bit keeps its read value and `write_grant` is 0.
- R4: A translation request with write intent to an entry whose write bit is 0 completes without a fault. It returns `write_grant` 0 and leaves the dirty bit as read.
- R5: When the updated image equals the read entry, no memory request is issued. `done_ok` pulses in the cycle after `start` is taken, with `pte_final` equal to the read entry.
- R6: Otherwise a compare-and-swap is requested to `walk_addr`. Its compare value is the read entry and its swap value is the updated image. The request is held stable until `mem_req_ready`.
- R7: A response equal to the compare value pulses `done_ok`, with `pte_final` equal to the swap value and `write_grant` as defined in R3.
- R8: A response that differs from the compare value pulses `walk_restart`. `pte_final` is then the returned entry and `write_grant` is 0.
- R9: After MAX_RETRY consecutive restarts, the next mismatch pulses `retry_limit_err` instead of `walk_restart`. Any other outcome clears the restart count.
- R10: An error response pulses `access_fault`, returns the read entry unchanged with `write_grant` 0, and takes priority over the response data.
- R11: Exactly one outcome pulse (`done_ok`, `walk_restart`, `retry_limit_err`, `access_fault`) follows each accepted `start`. For a memory operation, it comes in the cycle after the response.
- R12: After reset, `mem_req_valid`, `busy`, `write_grant`, `pte_final` and all outcome pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an update; taken only while idle |
| walk_pte | input | PTE_W | Leaf entry image read by the walker |
| walk_addr | input | ADDR_W | Memory address of the leaf entry |
| acc_kind | input | 2 | Access kind (R1) |
| no_write | input | 1 | No-write flag of a translation request |
| mem_req_valid | output | 1 | Compare-and-swap request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_cmp | output | PTE_W | Compare value |
| mem_req_swap | output | PTE_W | Swap value |
| mem_rsp_valid | input | 1 | Response valid |
| mem_rsp_data | input | PTE_W | Entry value found in memory |
| mem_rsp_err | input | 1 | Response carries an error |
| busy | output | 1 | Operation in progress |
| done_ok | output | 1 | Pulse: completed successfully |
| walk_restart | output | 1 | Pulse: entry changed, walker must refetch |
| retry_limit_err | output | 1 | Pulse: restart limit exceeded |
| access_fault | output | 1 | Pulse: memory error |
| pte_final | output | PTE_W | Resulting entry image |
| write_grant | output | 1 | Write permission to report |

## Verification
A mismatching response can arrive while the restart count already stands at its limit. The two functions then meet in one cycle: the compare result and the limit check decide between `walk_restart` and `retry_limit_err`. The bench provokes this with a chain of mismatching responses to the same entry, one more than the limit allows. It judges each pulse against a restart count it keeps itself. It also inserts error and matching responses in the middle of a chain, and checks that the next chain starts counting from zero.

// File: rtl/pte_ad_pkg.sv
package pte_ad_pkg;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_XLAT  = 2'd2,
    KIND_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } upd_state_e;

  // Write intent: plain write, or translation request without its no-write flag
  function automatic logic wants_write(input logic [1:0] kind, input logic nw);
    return (kind == KIND_WRITE) || ((kind == KIND_XLAT) && !nw);
  endfunction

endpackage

// File: rtl/pte_ad_image.sv
module pte_ad_image
  import pte_ad_pkg::*;
#(
  parameter int PTE_W = 64,
  parameter int A_POS = 6,
  parameter int D_POS = 7,
  parameter int W_POS = 2
) (
  input  logic [PTE_W-1:0] pte_old,
  input  logic [1:0]       kind,
  input  logic             no_write,
  output logic [PTE_W-1:0] pte_new,
  output logic             grant_wr,
  output logic             no_change
);

  localparam logic [PTE_W-1:0] A_MASK = PTE_W'(1) << A_POS;
  localparam logic [PTE_W-1:0] D_MASK = PTE_W'(1) << D_POS;

  function automatic logic [PTE_W-1:0] mark(input logic [PTE_W-1:0] p, input logic dirty);
    return p | A_MASK | (dirty ? D_MASK : '0);
  endfunction

  logic intent_wr;

  always_comb begin
    intent_wr = wants_write(kind, no_write);
    grant_wr  = intent_wr & pte_old[W_POS];
    pte_new   = mark(pte_old, grant_wr);
    no_change = (pte_new == pte_old);
  end

endmodule

// File: rtl/pte_ad_retry.sv
module pte_ad_retry #(
  parameter int MAX_RETRY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bump,
  input  logic clear,
  output logic at_limit
);

  localparam int CW = (MAX_RETRY < 2) ? 1 : $clog2(MAX_RETRY + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_RETRY);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (bump && (cnt_q != LIMIT)) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign at_limit = (cnt_q == LIMIT);

endmodule

// File: rtl/pte_ad_updater.sv
module pte_ad_updater
  import pte_ad_pkg::*;
#(
  parameter int PTE_W     = 64,
  parameter int ADDR_W    = 56,
  parameter int A_POS     = 6,
  parameter int D_POS     = 7,
  parameter int W_POS     = 2,
  parameter int MAX_RETRY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PTE_W-1:0]  walk_pte,
  input  logic [ADDR_W-1:0] walk_addr,
  input  logic [1:0]        acc_kind,
  input  logic              no_write,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [PTE_W-1:0]  mem_req_cmp,
  output logic [PTE_W-1:0]  mem_req_swap,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              busy,
  output logic              done_ok,
  output logic              walk_restart,
  output logic              retry_limit_err,
  output logic              access_fault,
  output logic [PTE_W-1:0]  pte_final,
  output logic              write_grant
);

  upd_state_e        st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PTE_W-1:0]  cmp_q;
  logic [PTE_W-1:0]  swap_q;
  logic              grant_q;

  logic [PTE_W-1:0]  img_pte;
  logic              img_grant;
  logic              img_skip;
  logic              retry_at_limit;

  // Named internal events
  logic start_take;
  logic cas_fire;
  logic rsp_take;
  logic rsp_same;
  logic rsp_mismatch;
  logic retry_bump;
  logic retry_clear;

  pte_ad_image #(
    .PTE_W(PTE_W), .A_POS(A_POS), .D_POS(D_POS), .W_POS(W_POS)
  ) u_image (
    .pte_old  (walk_pte),
    .kind     (acc_kind),
    .no_write (no_write),
    .pte_new  (img_pte),
    .grant_wr (img_grant),
    .no_change(img_skip)
  );

  assign start_take   = start && (st_q == ST_IDLE);
  assign cas_fire     = mem_req_valid && mem_req_ready;
  assign rsp_take     = (st_q == ST_WAIT) && mem_rsp_valid;
  assign rsp_same     = (mem_rsp_data == cmp_q);
  assign rsp_mismatch = rsp_take && !mem_rsp_err && !rsp_same;
  assign retry_bump   = rsp_mismatch && !retry_at_limit;
  assign retry_clear  = (start_take && img_skip)
                      || (rsp_take && (mem_rsp_err || rsp_same))
                      || (rsp_mismatch && retry_at_limit);

  pte_ad_retry #(.MAX_RETRY(MAX_RETRY)) u_retry (
    .clk     (clk),
    .rst_n   (rst_n),
    .bump    (retry_bump),
    .clear   (retry_clear),
    .at_limit(retry_at_limit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q            <= ST_IDLE;
      addr_q          <= '0;
      cmp_q           <= '0;
      swap_q          <= '0;
      grant_q         <= 1'b0;
      done_ok         <= 1'b0;
      walk_restart    <= 1'b0;
      retry_limit_err <= 1'b0;
      access_fault    <= 1'b0;
      pte_final       <= '0;
      write_grant     <= 1'b0;
    end else begin
      done_ok         <= 1'b0;
      walk_restart    <= 1'b0;
      retry_limit_err <= 1'b0;
      access_fault    <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start_take) begin
            if (img_skip) begin
              done_ok     <= 1'b1;
              pte_final   <= walk_pte;
              write_grant <= img_grant;
            end else begin
              st_q    <= ST_ISSUE;
              addr_q  <= walk_addr;
              cmp_q   <= walk_pte;
              swap_q  <= img_pte;
              grant_q <= img_grant;
            end
          end
        end
        ST_ISSUE: begin
          if (cas_fire) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_take) begin
            st_q <= ST_IDLE;
            if (mem_rsp_err) begin
              access_fault <= 1'b1;
              pte_final    <= cmp_q;
              write_grant  <= 1'b0;
            end else if (rsp_same) begin
              done_ok     <= 1'b1;
              pte_final   <= swap_q;
              write_grant <= grant_q;
            end else begin
              if (retry_at_limit) retry_limit_err <= 1'b1;
              else                walk_restart    <= 1'b1;
              pte_final   <= mem_rsp_data;
              write_grant <= 1'b0;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (st_q == ST_ISSUE);
  assign mem_req_addr  = addr_q;
  assign mem_req_cmp   = cmp_q;
  assign mem_req_swap  = swap_q;
  assign busy          = (st_q != ST_IDLE);

endmodule

// File: rtl/pte_ad_updater_chk.sv
module pte_ad_updater_chk #(
  parameter int PTE_W     = 64,
  parameter int ADDR_W    = 56,
  parameter int A_POS     = 6,
  parameter int D_POS     = 7,
  parameter int MAX_RETRY = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [PTE_W-1:0]  mem_req_cmp,
  input logic [PTE_W-1:0]  mem_req_swap,
  input logic              mem_rsp_err,
  input logic              rsp_take,
  input logic              rsp_same,
  input logic              done_ok,
  input logic              walk_restart,
  input logic              retry_limit_err,
  input logic              access_fault,
  input logic [PTE_W-1:0]  pte_final,
  input logic              write_grant
);

  int consec;

  always_ff @(posedge clk) begin
    if (!rst_n) consec <= 0;
    else if (walk_restart) consec <= consec + 1;
    else if (done_ok || retry_limit_err || access_fault) consec <= 0;
  end

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_cmp) && $stable(mem_req_swap));

  // R6
  req_changes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_swap[A_POS] && (mem_req_cmp != mem_req_swap));

  // R11
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_ok, walk_restart, retry_limit_err, access_fault}));

  // R2
  accessed_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |-> pte_final[A_POS]);

  // R3
  grant_needs_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    write_grant && done_ok |-> pte_final[D_POS]);

  // R10
  fault_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    access_fault |-> !write_grant);

  // R10
  err_to_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take && mem_rsp_err |=> access_fault);

  // R8
  mismatch_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take && !mem_rsp_err && !rsp_same |=> (walk_restart || retry_limit_err) && !write_grant);

  // R9
  restart_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_restart |-> consec < MAX_RETRY);

  // R9
  limit_at_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_limit_err |-> consec == MAX_RETRY);

endmodule

bind pte_ad_updater pte_ad_updater_chk #(
  .PTE_W(PTE_W), .ADDR_W(ADDR_W), .A_POS(A_POS), .D_POS(D_POS), .MAX_RETRY(MAX_RETRY)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .mem_req_valid  (mem_req_valid),
  .mem_req_ready  (mem_req_ready),
  .mem_req_addr   (mem_req_addr),
  .mem_req_cmp    (mem_req_cmp),
  .mem_req_swap   (mem_req_swap),
  .mem_rsp_err    (mem_rsp_err),
  .rsp_take       (rsp_take),
  .rsp_same       (rsp_same),
  .done_ok        (done_ok),
  .walk_restart   (walk_restart),
  .retry_limit_err(retry_limit_err),
  .access_fault   (access_fault),
  .pte_final      (pte_final),
  .write_grant    (write_grant)
);

// File: tb/test_pte_ad_updater.sv
module test_pte_ad_updater;

  localparam int PW   = 16;
  localparam int AW   = 16;
  localparam int MAXR = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [PW-1:0] walk_pte = '0;
  logic [AW-1:0] walk_addr = '0;
  logic [1:0]    acc_kind = '0;
  logic          no_write = 1'b0;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic [PW-1:0] mem_req_cmp;
  logic [PW-1:0] mem_req_swap;
  logic          mem_rsp_valid = 1'b0;
  logic [PW-1:0] mem_rsp_data = '0;
  logic          mem_rsp_err = 1'b0;
  logic          busy, done_ok, walk_restart, retry_limit_err, access_fault;
  logic [PW-1:0] pte_final;
  logic          write_grant;

  int n_checks = 0;
  int n_fail = 0;
  int rcnt = 0;
  logic [AW-1:0] addr_ctr = 16'h1000;

  always #10 clk = ~clk;

  pte_ad_updater #(
    .PTE_W(PW), .ADDR_W(AW), .A_POS(6), .D_POS(7), .W_POS(2), .MAX_RETRY(MAXR)
  ) i_pte_ad_updater (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // outc: 0 match, 1 mismatch, 2 error
  task automatic run_op(input logic [PW-1:0] pte, input logic [1:0] kind, input logic nw,
                        input int outc, input int dly, input logic [PW-1:0] alt);
    logic wi, nd;
    logic [PW-1:0] img;
    wi  = (kind == 2'd1) || (kind == 2'd2 && !nw);
    nd  = wi && pte[2];
    img = pte | 16'h0040 | (nd ? 16'h0080 : 16'h0000);
    addr_ctr = addr_ctr + 16'h0008;
    @(negedge clk);
    start = 1'b1; walk_pte = pte; walk_addr = addr_ctr; acc_kind = kind; no_write = nw;
    @(negedge clk);
    start = 1'b0;
    if (img == pte) begin
      // R5 no memory operation, immediate completion
      check(done_ok && !mem_req_valid, "R5", "skip done", {done_ok, mem_req_valid}, 2'b10);
      check(pte_final == pte, "R2", "skip image", pte_final, pte);
      check(write_grant == nd, "R3", "skip grant", write_grant, nd);
      rcnt = 0;
      return;
    end
    check(mem_req_valid && !done_ok, "R5", "req issued", {mem_req_valid, done_ok}, 2'b10);
    check(mem_req_cmp == pte, "R6", "cmp", mem_req_cmp, pte);
    check(mem_req_swap == img, "R6", "swap (R2/R3 image)", mem_req_swap, img);
    check(mem_req_addr == addr_ctr, "R6", "addr", mem_req_addr, addr_ctr);
    repeat (dly) @(negedge clk);
    if (dly > 0)
      check(mem_req_valid && mem_req_swap == img, "R6", "held", mem_req_swap, img);
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = (outc == 0) ? pte : alt;
    mem_rsp_err   = (outc == 2);
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; mem_rsp_data = '0;
    if (outc == 0) begin
      check(done_ok && !walk_restart && !access_fault && !retry_limit_err, "R7", "ok pulse",
            {done_ok, walk_restart, retry_limit_err, access_fault}, 4'b1000);
      check(pte_final == img, "R7", "final", pte_final, img);
      check(write_grant == nd, "R3", "grant", write_grant, nd);
      if (kind == 2'd2 && !nw && !pte[2])
        check(!write_grant && pte_final[7] == pte[7], "R4", "ro xlat", write_grant, 0);
      rcnt = 0;
    end else if (outc == 2) begin
      check(access_fault && !done_ok && !walk_restart && !retry_limit_err, "R10", "fault pulse",
            {done_ok, walk_restart, retry_limit_err, access_fault}, 4'b0001);
      check(pte_final == pte && !write_grant, "R10", "fault image", pte_final, pte);
      rcnt = 0;
    end else if (rcnt == MAXR) begin
      check(retry_limit_err && !walk_restart && !done_ok, "R9", "limit pulse",
            {done_ok, walk_restart, retry_limit_err, access_fault}, 4'b0010);
      rcnt = 0;
    end else begin
      check(walk_restart && !retry_limit_err && !done_ok, "R8", "restart pulse",
            {done_ok, walk_restart, retry_limit_err, access_fault}, 4'b0100);
      check(pte_final == alt && !write_grant, "R8", "restart image", pte_final, alt);
      rcnt++;
    end
    check(!busy, "R11", "idle after outcome", busy, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R12 reset state
    check(!mem_req_valid && !busy && !done_ok && !walk_restart && !retry_limit_err
          && !access_fault && !write_grant && pte_final == '0, "R12", "reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 sweep over W/A/D, every kind and no-write flag, every outcome
    for (int b = 0; b < 8; b++) begin
      for (int kn = 0; kn < 8; kn++) begin
        for (int oc = 0; oc < 3; oc++) begin
          logic [PW-1:0] p;
          p = 16'h0311 | (b[0] ? 16'h0004 : 16'h0) | (b[1] ? 16'h0040 : 16'h0)
                       | (b[2] ? 16'h0080 : 16'h0);
          run_op(p, kn[2:1], kn[0], oc, (b + kn + oc) % 3, p ^ 16'h1000);
          if (oc == 1 && rcnt != 0) run_op(p, kn[2:1], kn[0], 0, 0, p);
        end
      end
    end

    // R9 restart limit: mismatch chain one longer than the limit
    for (int i = 0; i <= MAXR; i++) run_op(16'h0005, 2'd1, 1'b0, 1, 0, 16'h0105);
    check(rcnt == 0, "R9", "bench count wrapped", rcnt, 0);
    run_op(16'h0005, 2'd1, 1'b0, 1, 0, 16'h0205);   // fresh chain: restart again
    // R10 error in the middle of a chain clears the count
    run_op(16'h0005, 2'd1, 1'b0, 2, 1, 16'h0405);
    for (int i = 0; i <= MAXR; i++) run_op(16'h0001, 2'd0, 1'b0, 1, 0, 16'h0801);
    // R9 success mid-chain clears the count
    run_op(16'h0001, 2'd0, 1'b0, 1, 0, 16'h0801);
    run_op(16'h0001, 2'd0, 1'b0, 0, 2, 16'h0001);
    for (int i = 0; i <= MAXR; i++) run_op(16'h0004, 2'd2, 1'b0, 1, 0, 16'h2004);

    // R4 read-only translation request with write intent, explicit
    run_op(16'h0001, 2'd2, 1'b0, 0, 0, 16'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule